// File: doc/BRIEF.md
# One-Wire Bus Master Controller

This block is a single-bit bus master for a one-wire, open-drain data line with an external pull-up. Software programs a time-base divider so that one internal timing unit lasts one microsecond, then starts one operation at a time by writing a start bit into the control register: a bus reset with presence detection, a slot that writes a zero, or a slot that writes a one and at the same time reads the bit a device returns. The start bit reads back as 1 while the operation runs and clears itself when the operation ends.

All bus waveforms are timed by a prescaler tick derived from the system clock. The line is only ever pulled low (`owl_oe` high); a released line floats high through the pull-up. The returned line level passes through a synchroniser before it is sampled. A two-bit completion status register with write-one-to-clear semantics and a matching enable register produce a level interrupt output.

Top module: `owm_master`

## Requirements
- R1: After reset, the control register (offset 0x00), the divider (0x02), the status register (0x0A) and the enable register (0x0C) all read 0x00, and `owl_oe` and `irq` are 0.
- R2: The divider at offset 0x02 is read/write; with value N every timing unit lasts N+1 system clocks.
- R3: Writing the control register with bit 7 set starts a bus reset: `owl_oe` is high for exactly 480 units from the write edge, and bit 7 reads 1 for exactly 960 units from the write edge and 0 afterwards.
- R4: Control bit 6 reads 1 after a bus reset when the line was low 70 units after the release, and 0 when it was high; it is cleared when a new reset starts.
- R5: Writing control bit 5 (with bit 7 clear) starts a write-zero slot: `owl_oe` high for exactly 60 units, bit 5 reading 1 for exactly 70 units; control bit 3 then reads 0.
- R6: Writing control bit 4 (with bits 7 and 5 clear) starts a write-one/read slot: `owl_oe` high for exactly 6 units, bit 4 reading 1 for exactly 70 units, and control bit 3 afterwards holding the line level sampled 15 units into the slot.
- R7: Start bits are prioritised bit 7 over bit 5 over bit 4, so at most one operation runs; a control write with none of them set starts nothing.
- R8: A control register write while any operation is busy is ignored.
- R9: `owl_oe` is high only while a reset or slot is actively driving the line low.
- R10: Status bit 0 (offset 0x0A) is set when a reset sequence ends and bit 1 when a slot ends; writing 1 to a bit clears it, and a set in the same cycle as the clear wins.
- R11: `irq` is high when any status bit is 1 whose enable bit at 0x0C is 1; the offsets 0x04, 0x06 and 0x08 read 0x00 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| owl_in | input | 1 | Sensed level of the data line |
| owl_oe | output | 1 | Pull the data line low when 1 |
| irq | output | 1 | Level interrupt from enabled status bits |

## Verification
The end of a slot, which sets a status bit, and a software write that clears the same bit can land on one clock edge. The bench counts clocks from the start edge of a read slot, places the clearing write exactly on the completion edge, and then expects the status bit still to read 1 and the busy bit to read 0. A second case issues a reset start while a slot is busy, so that the slot end and the ignored start do not combine into a late reset.

// File: rtl/owm_pkg.sv
package owm_pkg;
   localparam int ADDR_W = 4;
   localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
   localparam logic [ADDR_W-1:0] OFS_DIV  = 4'h2;
   localparam logic [ADDR_W-1:0] OFS_STAT = 4'hA;
   localparam logic [ADDR_W-1:0] OFS_IEN  = 4'hC;

   localparam int BIT_RST  = 7;
   localparam int BIT_PRES = 6;
   localparam int BIT_W0   = 5;
   localparam int BIT_W1   = 4;
   localparam int BIT_RX   = 3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RLOW  = 2'd1,
      ST_RWAIT = 2'd2,
      ST_SLOT  = 2'd3
   } seq_st_t;
endpackage

// File: rtl/owm_tick.sv
module owm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div,
   input  logic             restart,
   output logic             tick
);
   logic [DIV_W-1:0] pcnt;

   assign tick = (pcnt >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              pcnt <= '0;
      else if (restart || tick) pcnt <= '0;
      else                      pcnt <= pcnt + 1'b1;
   end
endmodule

// File: rtl/owm_sync.sv
module owm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] sr;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= d;
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = sr[STAGES-1];
endmodule

// File: rtl/owm_seq.sv
module owm_seq
   import owm_pkg::*;
#(
   parameter int RST_LOW  = 480,
   parameter int PRES_AT  = 70,
   parameter int RST_REC  = 480,
   parameter int W0_LOW   = 60,
   parameter int W1_LOW   = 6,
   parameter int RD_AT    = 15,
   parameter int SLOT_LEN = 70
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic start_rst,
   input  logic start_w0,
   input  logic start_w1,
   input  logic line_s,
   output logic launch,
   output logic rst_busy,
   output logic w0_busy,
   output logic w1_busy,
   output logic pres,
   output logic rx,
   output logic done_rst,
   output logic done_slot,
   output logic oe
);
   localparam int CW = $clog2(RST_LOW + RST_REC + SLOT_LEN + 1);
   localparam logic [CW-1:0] T_RLOW_END = CW'(RST_LOW - 1);
   localparam logic [CW-1:0] T_PRES     = CW'(PRES_AT - 1);
   localparam logic [CW-1:0] T_RREC_END = CW'(RST_REC - 1);
   localparam logic [CW-1:0] T_RD       = CW'(RD_AT - 1);
   localparam logic [CW-1:0] T_SLOT_END = CW'(SLOT_LEN - 1);
   localparam logic [CW-1:0] T_W0_LOW   = CW'(W0_LOW);
   localparam logic [CW-1:0] T_W1_LOW   = CW'(W1_LOW);

   generate
      if (RST_LOW < 1 || RST_REC < 1 || SLOT_LEN < 1) begin : g_bad_len
         $error("owm_seq: phase lengths must be at least one unit");
      end
      if (PRES_AT < 1 || PRES_AT > RST_REC) begin : g_bad_pres
         $error("owm_seq: presence sample must fall inside the recovery phase");
      end
      if (RD_AT < 1 || RD_AT > SLOT_LEN || W1_LOW >= RD_AT) begin : g_bad_rd
         $error("owm_seq: read sample must follow the write-one low time");
      end
      if (W0_LOW > SLOT_LEN || W1_LOW < 1) begin : g_bad_low
         $error("owm_seq: low times must fit the slot");
      end
   endgenerate

   seq_st_t        st;
   logic [CW-1:0]  tcnt;
   logic           is_w0;
   logic           start_any;

   assign start_any = start_rst | start_w0 | start_w1;
   assign launch    = (st == ST_IDLE) && start_any;

   assign rst_busy  = (st == ST_RLOW) || (st == ST_RWAIT);
   assign w0_busy   = (st == ST_SLOT) && is_w0;
   assign w1_busy   = (st == ST_SLOT) && !is_w0;

   assign done_rst  = (st == ST_RWAIT) && tick && (tcnt == T_RREC_END);
   assign done_slot = (st == ST_SLOT)  && tick && (tcnt == T_SLOT_END);

   assign oe = (st == ST_RLOW) ||
               ((st == ST_SLOT) && (tcnt < (is_w0 ? T_W0_LOW : T_W1_LOW)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= ST_IDLE;
         tcnt  <= '0;
         is_w0 <= 1'b0;
         pres  <= 1'b0;
         rx    <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               tcnt <= '0;
               if (start_rst) begin
                  st   <= ST_RLOW;
                  pres <= 1'b0;
               end else if (start_w0 || start_w1) begin
                  st    <= ST_SLOT;
                  is_w0 <= start_w0;
               end
            end
            ST_RLOW: begin
               if (tick) begin
                  if (tcnt == T_RLOW_END) begin
                     st   <= ST_RWAIT;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_RWAIT: begin
               if (tick) begin
                  if (tcnt == T_PRES) pres <= ~line_s;
                  if (tcnt == T_RREC_END) begin
                     st   <= ST_IDLE;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            ST_SLOT: begin
               if (tick) begin
                  if (tcnt == T_RD) rx <= line_s;
                  if (tcnt == T_SLOT_END) begin
                     st   <= ST_IDLE;
                     tcnt <= '0;
                  end else begin
                     tcnt <= tcnt + 1'b1;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/owm_master.sv
module owm_master
   import owm_pkg::*;
#(
   parameter int DIV_W       = 8,
   parameter int SYNC_STAGES = 2,
   parameter int RST_LOW     = 480,
   parameter int PRES_AT     = 70,
   parameter int RST_REC     = 480,
   parameter int W0_LOW      = 60,
   parameter int W1_LOW      = 6,
   parameter int RD_AT       = 15,
   parameter int SLOT_LEN    = 70
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [7:0]        bus_wdata,
   output logic [7:0]        bus_rdata,
   input  logic              owl_in,
   output logic              owl_oe,
   output logic              irq
);
   localparam int STAT_W = 2;

   generate
      if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
         $error("owm_master: divider must fit a byte register");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("owm_master: at least one synchroniser stage is needed");
      end
   endgenerate

   logic [DIV_W-1:0]  div_q;
   logic [STAT_W-1:0] stat_q;
   logic [STAT_W-1:0] ien_q;

   logic tick, launch, line_s;
   logic rst_busy, w0_busy, w1_busy, pres, rx, done_rst, done_slot;
   logic [2:0] ctl_busy;
   logic ctl_wr, idle;
   logic start_rst, start_w0, start_w1;

   assign ctl_busy  = {rst_busy, w0_busy, w1_busy};
   assign idle      = (ctl_busy == 3'b000);
   assign ctl_wr    = bus_wr && (bus_addr == OFS_CTRL);
   assign start_rst = ctl_wr && idle && bus_wdata[BIT_RST];
   assign start_w0  = ctl_wr && idle && !bus_wdata[BIT_RST] && bus_wdata[BIT_W0];
   assign start_w1  = ctl_wr && idle && !bus_wdata[BIT_RST] && !bus_wdata[BIT_W0]
                      && bus_wdata[BIT_W1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_q  <= '0;
         stat_q <= '0;
         ien_q  <= '0;
      end else begin
         if (bus_wr && bus_addr == OFS_DIV) div_q <= bus_wdata[DIV_W-1:0];
         if (bus_wr && bus_addr == OFS_IEN) ien_q <= bus_wdata[STAT_W-1:0];
         stat_q <= (stat_q & ~((bus_wr && bus_addr == OFS_STAT) ?
                               bus_wdata[STAT_W-1:0] : {STAT_W{1'b0}}))
                   | {done_slot, done_rst};
      end
   end

   always_comb begin
      bus_rdata = 8'h00;
      unique case (bus_addr)
         OFS_CTRL: begin
            bus_rdata[BIT_RST]  = rst_busy;
            bus_rdata[BIT_PRES] = pres;
            bus_rdata[BIT_W0]   = w0_busy;
            bus_rdata[BIT_W1]   = w1_busy;
            bus_rdata[BIT_RX]   = rx;
         end
         OFS_DIV:  bus_rdata[DIV_W-1:0]  = div_q;
         OFS_STAT: bus_rdata[STAT_W-1:0] = stat_q;
         OFS_IEN:  bus_rdata[STAT_W-1:0] = ien_q;
         default:  bus_rdata = 8'h00;
      endcase
   end

   assign irq = |(stat_q & ien_q);

   owm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .div(div_q), .restart(launch), .tick(tick)
   );

   owm_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(owl_in), .q(line_s)
   );

   owm_seq #(
      .RST_LOW(RST_LOW), .PRES_AT(PRES_AT), .RST_REC(RST_REC),
      .W0_LOW(W0_LOW), .W1_LOW(W1_LOW), .RD_AT(RD_AT), .SLOT_LEN(SLOT_LEN)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick),
      .start_rst(start_rst), .start_w0(start_w0), .start_w1(start_w1),
      .line_s(line_s), .launch(launch),
      .rst_busy(rst_busy), .w0_busy(w0_busy), .w1_busy(w1_busy),
      .pres(pres), .rx(rx), .done_rst(done_rst), .done_slot(done_slot),
      .oe(owl_oe)
   );
endmodule

// File: rtl/owm_chk.sv
module owm_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       oe,
   input logic [2:0] busy,
   input logic [1:0] stat
);
   // R9: the line is pulled only while an operation runs
   p_oe_needs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe |-> (busy != 3'b000));

   // R7: never two operations at once
   p_one_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(busy));

   // R8: a running operation is never replaced by another
   p_busy_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy != 3'b000) |=> ((busy == 3'b000) || (busy == $past(busy))));

   // R10: end of reset leaves status bit 0 set
   p_rst_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[2]) |-> stat[0]);

   // R10: end of a slot leaves status bit 1 set
   p_slot_done_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy[1]) || $fell(busy[0])) |-> stat[1]);

   // R3, R5, R6: every operation begins with the line pulled low
   p_start_drives_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) == 3'b000 && busy != 3'b000) |-> oe);
endmodule

bind owm_master owm_chk u_owm_chk (
   .clk(clk), .rst_n(rst_n), .oe(owl_oe), .busy(ctl_busy), .stat(stat_q)
);

// File: tb/test_owm_master.sv
module test_owm_master;
   localparam int CLK_PER = 10;
   localparam logic [3:0] A_CTRL = 4'h0, A_DIV = 4'h2, A_STAT = 4'hA, A_IEN = 4'hC;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = 4'h0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;
   logic       owl_in;
   logic       owl_oe;
   logic       irq;

   int n_cmp = 0;
   int n_bad = 0;
   int unit  = 1;
   int dev_mode = 0;
   bit finished = 0;

   int  rel_cnt  = 100000;
   int  fall_cnt = 100000;
   logic oe_prev = 1'b0;
   logic dev_pull;

   always #(CLK_PER/2) clk = ~clk;

   owm_master i_owm_master (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .owl_in(owl_in),
      .owl_oe(owl_oe), .irq(irq)
   );

   // device model: presence pulse after release, or answering a zero in a read slot
   always @(posedge clk) begin
      oe_prev  <= owl_oe;
      rel_cnt  <= (oe_prev && !owl_oe) ? 0 : ((rel_cnt < 100000) ? rel_cnt + 1 : rel_cnt);
      fall_cnt <= (!oe_prev && owl_oe) ? 0 : ((fall_cnt < 100000) ? fall_cnt + 1 : fall_cnt);
   end
   assign dev_pull = (dev_mode == 1 && rel_cnt >= 20*unit && rel_cnt < 150*unit) ||
                     (dev_mode == 2 && fall_cnt < 30*unit);
   assign owl_in = ~(owl_oe | dev_pull);

   task automatic chk(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [3:0] a, output int v);
      bus_addr = a;
      #1;
      v = int'(bus_rdata);
   endtask

   task automatic run_op(input logic [7:0] cmd, output int low, output int busy);
      int v;
      wr_reg(A_CTRL, cmd);
      low = 0; busy = 0;
      for (int i = 0; i < 20000; i++) begin
         rd_reg(A_CTRL, v);
         if ((v & 8'hB0) == 0) break;
         busy++;
         if (owl_oe) low++;
         @(negedge clk);
      end
   endtask

   task automatic wait_idle();
      int v;
      for (int i = 0; i < 20000; i++) begin
         rd_reg(A_CTRL, v);
         if ((v & 8'hB0) == 0) break;
         @(negedge clk);
      end
   endtask

   initial begin
      #(CLK_PER * 180000);
      if (!finished) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got 1 expected 0");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int v, lo, bz;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_reg(A_CTRL, v); chk("R1 ctrl", v, 0);
      rd_reg(A_DIV, v);  chk("R1 div", v, 0);
      rd_reg(A_STAT, v); chk("R1 stat", v, 0);
      rd_reg(A_IEN, v);  chk("R1 ien", v, 0);
      chk("R1 oe", int'(owl_oe), 0);
      chk("R1 irq", int'(irq), 0);

      // sweep of divider values over every operation
      for (int d = 0; d < 4; d++) begin
         unit = d + 1;
         wr_reg(A_DIV, 8'(d));
         rd_reg(A_DIV, v); chk("R2 div readback", v, d);

         dev_mode = 0;
         run_op(8'h80, lo, bz);
         chk("R3 R2 reset low width", lo, 480*unit);
         chk("R3 reset busy length", bz, 960*unit);
         rd_reg(A_CTRL, v); chk("R4 no presence", (v >> 6) & 1, 0);
         rd_reg(A_STAT, v); chk("R10 reset done flag", v & 1, 1);
         wr_reg(A_STAT, 8'h03);

         dev_mode = 1;
         run_op(8'h80, lo, bz);
         rd_reg(A_CTRL, v); chk("R4 presence seen", (v >> 6) & 1, 1);
         dev_mode = 0;

         run_op(8'h20, lo, bz);
         chk("R5 write0 low width", lo, 60*unit);
         chk("R5 write0 busy length", bz, 70*unit);
         rd_reg(A_CTRL, v); chk("R5 write0 sample", (v >> 3) & 1, 0);
         rd_reg(A_CTRL, v); chk("R4 presence kept over slot", (v >> 6) & 1, 1);

         run_op(8'h10, lo, bz);
         chk("R6 write1 low width", lo, 6*unit);
         chk("R6 write1 busy length", bz, 70*unit);
         rd_reg(A_CTRL, v); chk("R6 read one", (v >> 3) & 1, 1);

         dev_mode = 2;
         run_op(8'h10, lo, bz);
         rd_reg(A_CTRL, v); chk("R6 read zero", (v >> 3) & 1, 0);
         dev_mode = 0;
         rd_reg(A_STAT, v); chk("R10 slot done flag", (v >> 1) & 1, 1);
         wr_reg(A_STAT, 8'h03);
         rd_reg(A_STAT, v); chk("R10 write one clears", v, 0);
      end

      unit = 1;
      wr_reg(A_DIV, 8'h00);

      // R7 priority
      wr_reg(A_CTRL, 8'hB0);
      rd_reg(A_CTRL, v); chk("R7 reset beats slots", v & 8'hB0, 8'h80);
      wait_idle();
      wr_reg(A_CTRL, 8'h30);
      rd_reg(A_CTRL, v); chk("R7 write0 beats write1", v & 8'hB0, 8'h20);
      wait_idle();
      wr_reg(A_CTRL, 8'h48);
      rd_reg(A_CTRL, v); chk("R7 no start bit", v & 8'hB0, 0);
      chk("R7 R9 line idle", int'(owl_oe), 0);

      // R8 control write during slot ignored
      wr_reg(A_CTRL, 8'h10);
      repeat (20) @(negedge clk);
      wr_reg(A_CTRL, 8'h80);
      rd_reg(A_CTRL, v); chk("R8 slot still running", v & 8'hB0, 8'h10);
      wait_idle();
      repeat (5) @(negedge clk);
      rd_reg(A_CTRL, v); chk("R8 no late reset", v & 8'hB0, 0);
      chk("R8 R9 line released", int'(owl_oe), 0);

      // R10 set and clear on the same edge
      wr_reg(A_STAT, 8'h03);
      wr_reg(A_CTRL, 8'h10);
      repeat (68) @(negedge clk);
      wr_reg(A_STAT, 8'h02);
      rd_reg(A_STAT, v); chk("R10 set wins over clear", (v >> 1) & 1, 1);
      rd_reg(A_CTRL, v); chk("R6 busy ends on time", v & 8'hB0, 0);
      wr_reg(A_STAT, 8'h02);
      rd_reg(A_STAT, v); chk("R10 clear alone", (v >> 1) & 1, 0);

      // R11 interrupt and reserved offsets
      wr_reg(A_IEN, 8'h02);
      rd_reg(A_IEN, v); chk("R11 enable readback", v, 2);
      chk("R11 irq low without status", int'(irq), 0);
      wr_reg(A_CTRL, 8'h10);
      wait_idle();
      @(negedge clk);
      chk("R11 irq on slot end", int'(irq), 1);
      wr_reg(A_IEN, 8'h01);
      chk("R11 irq masked", int'(irq), 0);
      wr_reg(8'h06 >> 0, 8'hFF);
      wr_reg(4'h4, 8'hFF);
      wr_reg(4'h8, 8'hFF);
      rd_reg(4'h4, v); chk("R11 offset 4 reads zero", v, 0);
      rd_reg(4'h6, v); chk("R11 offset 6 reads zero", v, 0);
      rd_reg(4'h8, v); chk("R11 offset 8 reads zero", v, 0);
      chk("R11 R9 no activity", int'(owl_oe), 0);

      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule